// File: doc/BRIEF.md
# Half-Warp Memory Coalescing Checker

This block sits between the address stage of a sixteen-lane group and the memory port. Every lane presents its request in the same cycle. Each request has an active flag, a byte address and a size code. The block decides whether the whole group can go to memory as one wide transaction. If it can, it issues that single transaction. If it cannot, it issues one narrow transaction for each active lane, in ascending lane order. Transactions leave through a valid/ready handshake.

A group is taken when `grp_valid` and `grp_ready` are both high. `grp_ready` stays low until the group has been fully issued. A one-cycle `grp_done` pulse marks the end of the group. Two free-running counters report how many groups were merged and how many were split.

Size code encoding, used throughout: 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes, 3 = 16 bytes.

Top module: `hw_coalesce_chk`

## Requirements
- R1: While reset is held, and right after it is released, `grp_ready`=1, `tx_valid`=0, `grp_done`=0 and both counters are 0. Asserting reset in the middle of a group aborts that group.
- R2: A group merges into one transaction when all of the following hold:
  - every active lane has the same size code, and that code is 1, 2 or 3;
  - each active lane k addresses base + k*B, where B is the lane size in bytes;
  - base is aligned to 16*B.

  The merged transaction has `tx_merged`=1, `tx_addr`=base, `tx_len`=16*B and `tx_lane`=0. Its address is always aligned to its length.
- R3: Inactive lanes take no part in the rule checks, but they keep their slot. A group whose lane 0 is inactive, or which has only a few active lanes, still merges, with base equal to the region start.
- R4: Size code 0 (1 byte) never merges.
- R5: If any active lane's address is not a multiple of its size, the group is split.
- R6: If active lanes use different size codes, the group is split.
- R7: The group is split when lanes do not address their own word in ascending order (swapped lanes), or when the region start is not aligned to 16*B.
- R8: A split group issues exactly one transaction per active lane, in strictly ascending lane order, skipping inactive lanes. Each has `tx_merged`=0, `tx_addr` equal to that lane's address, `tx_len` equal to that lane's byte size, and `tx_lane` equal to the lane index.
- R9: While `tx_valid`=1 and `tx_ready`=0, the fields `tx_addr`, `tx_len` and `tx_lane` stay stable and `tx_valid` stays high. `grp_ready` is 0 from group acceptance until `grp_done`.
- R10: `grp_done` is high for exactly the one cycle after the final transaction handshake. A group with no active lanes issues nothing, and its `grp_done` comes one cycle after acceptance.
- R11: `cnt_merged` increments by one for each merged group. `cnt_split` increments by one for each split group that has at least one active lane. A group with no active lanes changes neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | Group request present |
| grp_ready | output | 1 | Block can accept a group |
| lane_act | input | LANES | Per-lane active flags |
| lane_addr | input | LANES*AW | Per-lane byte addresses, lane k at bits [k*AW +: AW] |
| lane_size | input | LANES*2 | Per-lane size codes, lane k at bits [2k +: 2] |
| tx_valid | output | 1 | Transaction valid |
| tx_ready | input | 1 | Memory accepts transaction |
| tx_addr | output | AW | Transaction byte address |
| tx_len | output | LW | Transaction length in bytes |
| tx_lane | output | LB | Lane served (0 for merged) |
| tx_merged | output | 1 | Transaction covers the whole group |
| grp_done | output | 1 | Group finished pulse |
| cnt_merged | output | CW | Merged-group count |
| cnt_split | output | CW | Split-group count |

## Verification
The main function is tried with several request shapes:
- Fully active, correctly placed groups at each wide size. These show that length and base scale with the size code.
- Sparse groups and groups with lane 0 inactive. These separate "inactive lanes keep their slot" from "inactive lanes are compacted".
- Single-fault groups, each breaking one rule: byte size, one misaligned lane, one odd size, swapped neighbours, and a region shifted by one word. Each must flip the outcome to the split path.

Runs with back-pressure on the transaction side show that fields hold steady and that lane order survives stalls.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_MERGE = 2'd1,
    SEQ_SPLIT = 2'd2
  } seq_st_e;

  // log2 of the byte size selected by a lane size code
  function automatic logic [2:0] size_shift(input logic [1:0] code);
    case (code)
      2'd0:    size_shift = 3'd0;
      2'd1:    size_shift = 3'd2;
      2'd2:    size_shift = 3'd3;
      default: size_shift = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/hwc_rule_check.sv
module hwc_rule_check
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int LW    = 9
) (
  input  logic [LANES-1:0]    lane_act,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*2-1:0]  lane_size,
  output logic                any_act,
  output logic                merge_ok,
  output logic [AW-1:0]       base,
  output logic [LW-1:0]       len
);
  localparam int LB = $clog2(LANES);
  localparam logic [AW-1:0] IDX_MASK = AW'(LANES - 1);

  logic [1:0]       ref_sz;
  logic [AW-1:0]    ref_addr;
  logic [2:0]       sh;
  logic [7:0]       sh_tag;
  logic [AW-1:0]    ref_tag;
  logic [AW-1:0]    low_mask;
  logic [LANES-1:0] lane_ok;

  // reference size and region tag come from the lowest active lane
  always_comb begin
    ref_sz   = 2'd0;
    ref_addr = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (lane_act[k]) begin
        ref_sz   = lane_size[k*2 +: 2];
        ref_addr = lane_addr[k*AW +: AW];
      end
    end
  end

  assign sh       = size_shift(ref_sz);
  assign sh_tag   = 8'(sh) + 8'(LB);
  assign ref_tag  = ref_addr >> sh_tag;
  assign low_mask = ~({AW{1'b1}} << sh);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] a;
    logic [1:0]    s;
    assign a = lane_addr[k*AW +: AW];
    assign s = lane_size[k*2 +: 2];
    assign lane_ok[k] = ~lane_act[k] |
                        ((s == ref_sz) &&
                         ((a & low_mask) == '0) &&
                         (((a >> sh) & IDX_MASK) == AW'(k)) &&
                         ((a >> sh_tag) == ref_tag));
  end

  assign any_act  = |lane_act;
  assign merge_ok = any_act && (ref_sz != 2'd0) && (&lane_ok);
  assign base     = ref_tag << sh_tag;
  assign len      = LW'(LANES) << sh;

endmodule

// File: rtl/hwc_issue_seq.sv
module hwc_issue_seq
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int LW    = 9,
  parameter int LB    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                take_merge,
  input  logic                take_any,
  input  logic [LANES-1:0]    take_act,
  input  logic [LANES*AW-1:0] take_addr,
  input  logic [LANES*2-1:0]  take_size,
  input  logic [AW-1:0]       take_base,
  input  logic [LW-1:0]       take_len,
  output logic                idle,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [AW-1:0]       tx_addr,
  output logic [LW-1:0]       tx_len,
  output logic [LB-1:0]       tx_lane,
  output logic                tx_merged,
  output logic                done
);
  seq_st_e          st_q, st_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic             done_q, done_d;
  logic [AW-1:0]    addr_q [LANES];
  logic [LANES*2-1:0] size_q;
  logic [AW-1:0]    base_q;
  logic [LW-1:0]    len_q;
  logic [LB-1:0]    cur;
  logic [1:0]       cur_sz;

  // lowest pending lane
  always_comb begin
    cur = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pend_q[k]) cur = LB'(k);
    end
  end

  assign cur_sz = size_q[cur*2 +: 2];

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    done_d = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (take) begin
          if (take_merge) begin
            st_d = SEQ_MERGE;
          end else if (take_any) begin
            st_d   = SEQ_SPLIT;
            pend_d = take_act;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SEQ_MERGE: begin
        if (tx_ready) begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
        end
      end
      SEQ_SPLIT: begin
        if (tx_ready) begin
          pend_d[cur] = 1'b0;
          if (pend_d == '0) begin
            st_d   = SEQ_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  // datapath capture, enabled only on group acceptance
  always_ff @(posedge clk) begin
    if (take) begin
      for (int k = 0; k < LANES; k++) addr_q[k] <= take_addr[k*AW +: AW];
      size_q <= take_size;
      base_q <= take_base;
      len_q  <= take_len;
    end
  end

  assign idle      = (st_q == SEQ_IDLE);
  assign tx_valid  = (st_q != SEQ_IDLE);
  assign tx_merged = (st_q == SEQ_MERGE);
  assign tx_addr   = tx_merged ? base_q : addr_q[cur];
  assign tx_len    = tx_merged ? len_q : (LW'(1) << size_shift(cur_sz));
  assign tx_lane   = tx_merged ? '0 : cur;
  assign done      = done_q;

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) &&
                                 $stable(tx_len) && $stable(tx_lane)));

  assert_lane_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_merged && tx_ready) |=>
      (!tx_valid || (!tx_merged && (tx_lane > $past(tx_lane)))));

  assert_merge_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_merged) |-> ((tx_addr & AW'(tx_len - 1'b1)) == '0));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idle && !$past(idle && !take)));

endmodule

// File: rtl/hwc_prof_cnt.sv
module hwc_prof_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          take_merge,
  input  logic          take_any,
  output logic [CW-1:0] cnt_merged,
  output logic [CW-1:0] cnt_split
);
  logic [CW-1:0] cm_q, cm_d, cs_q, cs_d;
  logic          cm_en, cs_en;

  assign cm_en = take && take_merge;
  assign cs_en = take && take_any && !take_merge;
  assign cm_d  = cm_q + 1'b1;
  assign cs_d  = cs_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_q <= '0;
      cs_q <= '0;
    end else begin
      if (cm_en) cm_q <= cm_d;
      if (cs_en) cs_q <= cs_d;
    end
  end

  assign cnt_merged = cm_q;
  assign cnt_split  = cs_q;

  assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_merged != $past(cnt_merged)) |->
      ((cnt_merged == $past(cnt_merged) + 1'b1) && (cnt_split == $past(cnt_split))));

endmodule

// File: rtl/hw_coalesce_chk.sv
module hw_coalesce_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int CW    = 16,
  localparam int LB   = $clog2(LANES),
  localparam int LW   = LB + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grp_valid,
  output logic                grp_ready,
  input  logic [LANES-1:0]    lane_act,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*2-1:0]  lane_size,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [AW-1:0]       tx_addr,
  output logic [LW-1:0]       tx_len,
  output logic [LB-1:0]       tx_lane,
  output logic                tx_merged,
  output logic                grp_done,
  output logic [CW-1:0]       cnt_merged,
  output logic [CW-1:0]       cnt_split
);
  logic          any_act, merge_ok, take, idle;
  logic [AW-1:0] m_base;
  logic [LW-1:0] m_len;

  hwc_rule_check #(.LANES(LANES), .AW(AW), .LW(LW)) rule_i (
    .lane_act (lane_act),
    .lane_addr(lane_addr),
    .lane_size(lane_size),
    .any_act  (any_act),
    .merge_ok (merge_ok),
    .base     (m_base),
    .len      (m_len)
  );

  assign take      = grp_valid && idle;
  assign grp_ready = idle;

  hwc_issue_seq #(.LANES(LANES), .AW(AW), .LW(LW), .LB(LB)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_merge(merge_ok),
    .take_any  (any_act),
    .take_act  (lane_act),
    .take_addr (lane_addr),
    .take_size (lane_size),
    .take_base (m_base),
    .take_len  (m_len),
    .idle      (idle),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_addr   (tx_addr),
    .tx_len    (tx_len),
    .tx_lane   (tx_lane),
    .tx_merged (tx_merged),
    .done      (grp_done)
  );

  hwc_prof_cnt #(.CW(CW)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_merge(merge_ok),
    .take_any  (any_act),
    .cnt_merged(cnt_merged),
    .cnt_split (cnt_split)
  );

endmodule

// File: tb/hw_coalesce_chk_tb_top.sv
module hw_coalesce_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int CW    = 16;
  localparam int LB    = 4;
  localparam int LW    = 9;

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] base;
    logic [15:0] act;
    logic [2:0]  pert;   // 0 none,1 misalign lane5,2 swap lanes2/3,3 lane7 size code 1
    logic        stall;
    logic        exp_m;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'd2, 32'h0000_1000, 16'hFFFF, 3'd0, 1'b0, 1'b1},  // R2 8B
    '{2'd1, 32'h0000_2040, 16'hFFFF, 3'd0, 1'b1, 1'b1},  // R2 4B stalled
    '{2'd3, 32'h0000_3100, 16'hFFFF, 3'd0, 1'b0, 1'b1},  // R2 16B
    '{2'd1, 32'h0000_4000, 16'hFFFE, 3'd0, 1'b0, 1'b1},  // R3 lane0 off
    '{2'd2, 32'h0000_0800, 16'h00F0, 3'd0, 1'b1, 1'b1},  // R3 sparse
    '{2'd0, 32'h0000_0100, 16'hFFFF, 3'd0, 1'b0, 1'b0},  // R4 bytes
    '{2'd1, 32'h0000_4000, 16'hFFFF, 3'd1, 1'b1, 1'b0},  // R5 misalign
    '{2'd2, 32'h0000_1000, 16'hFFFF, 3'd3, 1'b0, 1'b0},  // R6 mixed
    '{2'd1, 32'h0000_2040, 16'hFFFF, 3'd2, 1'b0, 1'b0},  // R7 swap
    '{2'd1, 32'h0000_2044, 16'hFFFF, 3'd0, 1'b0, 1'b0},  // R7 shifted region
    '{2'd3, 32'h0000_3100, 16'h000C, 3'd2, 1'b1, 1'b0}   // R8 sparse swapped
  };

  logic                clk = 1'b0;
  logic                rst_n;
  logic                grp_valid;
  logic                grp_ready;
  logic [LANES-1:0]    lane_act;
  logic [LANES*AW-1:0] lane_addr;
  logic [LANES*2-1:0]  lane_size;
  logic                tx_valid;
  logic                tx_ready;
  logic [AW-1:0]       tx_addr;
  logic [LW-1:0]       tx_len;
  logic [LB-1:0]       tx_lane;
  logic                tx_merged;
  logic                grp_done;
  logic [CW-1:0]       cnt_merged;
  logic [CW-1:0]       cnt_split;

  int total = 0;
  int bad   = 0;
  int exp_cm = 0;
  int exp_cs = 0;
  bit finished = 1'b0;

  logic [AW-1:0] ea [LANES];
  logic [1:0]    es [LANES];
  logic [AW-1:0] g_base;
  logic [1:0]    g_sz;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_coalesce_chk #(.LANES(LANES), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .lane_act(lane_act), .lane_addr(lane_addr), .lane_size(lane_size),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_len(tx_len),
    .tx_lane(tx_lane), .tx_merged(tx_merged), .grp_done(grp_done),
    .cnt_merged(cnt_merged), .cnt_split(cnt_split)
  );

  function automatic int bytes_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    logic [AW-1:0] t;
    g_base = v.base;
    g_sz   = v.sz;
    for (int k = 0; k < LANES; k++) begin
      ea[k] = v.base + AW'(k * bytes_of(v.sz));
      es[k] = v.sz;
    end
    if (v.pert == 3'd1) ea[5] = ea[5] + 1;
    if (v.pert == 3'd2) begin t = ea[2]; ea[2] = ea[3]; ea[3] = t; end
    if (v.pert == 3'd3) es[7] = 2'd1;
  endtask

  task automatic run_grp(input logic [LANES-1:0] act, input bit exp_m, input bit stall);
    int exp_n, idx, cyc, lane;
    bit seen_done;
    exp_n = exp_m ? 1 : $countones(act);
    @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      lane_addr[k*AW +: AW] = ea[k];
      lane_size[k*2 +: 2]   = es[k];
    end
    lane_act  = act;
    grp_valid = 1'b1;
    chk(grp_ready == 1'b1, "R9 ready before group", grp_ready, 1);
    @(negedge clk);
    grp_valid = 1'b0;
    idx = 0; cyc = 0; seen_done = 1'b0;
    lane = 0;
    while (lane < LANES && !act[lane]) lane++;
    while (cyc < 300) begin
      if (grp_done) begin seen_done = 1'b1; break; end
      chk(grp_ready == 1'b0, "R9 busy not ready", grp_ready, 0);
      chk(tx_valid == (idx < exp_n), "R8 tx_valid while pending", tx_valid, idx < exp_n);
      if (tx_valid) begin
        if (exp_m) begin
          chk(tx_merged == 1'b1, "R2 merged flag", tx_merged, 1);
          chk(tx_addr == g_base, "R2/R3 merged base", tx_addr, g_base);
          chk(int'(tx_len) == 16 * bytes_of(g_sz), "R2 merged length", tx_len, 16 * bytes_of(g_sz));
        end else begin
          chk(tx_merged == 1'b0, "R4-R7 split flag", tx_merged, 0);
          chk(int'(tx_lane) == lane, "R8 lane order", tx_lane, lane);
          chk(tx_addr == ea[lane], "R8 lane address", tx_addr, ea[lane]);
          chk(int'(tx_len) == bytes_of(es[lane]), "R8 lane length", tx_len, bytes_of(es[lane]));
        end
        tx_ready = stall ? ((cyc % 3) == 2) : 1'b1;
        if (tx_ready) begin
          idx++;
          lane++;
          while (lane < LANES && !act[lane]) lane++;
        end
      end else begin
        tx_ready = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b0;
    chk(seen_done, "R10 done seen", seen_done, 1);
    chk(idx == exp_n, "R8 transaction count", idx, exp_n);
    chk(tx_valid == 1'b0, "R10 no tx at done", tx_valid, 0);
    @(negedge clk);
    chk(grp_done == 1'b0, "R10 done single cycle", grp_done, 0);
    if (exp_m) exp_cm++;
    else if (act != '0) exp_cs++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_valid = 1'b0; tx_ready = 1'b0;
    lane_act = '0; lane_addr = '0; lane_size = '0;
    repeat (3) @(negedge clk);
    chk(grp_ready == 1'b1, "R1 reset ready", grp_ready, 1);
    chk(tx_valid == 1'b0, "R1 reset tx_valid", tx_valid, 0);
    chk(grp_done == 1'b0, "R1 reset done", grp_done, 0);
    chk(cnt_merged == '0 && cnt_split == '0, "R1 reset counters", {cnt_merged, cnt_split}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grp_ready == 1'b1 && tx_valid == 1'b0, "R1 after release", {grp_ready, tx_valid}, 2);

    for (int v = 0; v < NV; v++) begin
      build(VT[v]);
      run_grp(VT[v].act, VT[v].exp_m, VT[v].stall);
    end
    chk(int'(cnt_merged) == exp_cm, "R11 merged count", cnt_merged, exp_cm);
    chk(int'(cnt_split) == exp_cs, "R11 split count", cnt_split, exp_cs);

    // R10: group with no active lanes
    build(VT[0]);
    run_grp('0, 1'b0, 1'b0);
    chk(int'(cnt_merged) == exp_cm && int'(cnt_split) == exp_cs,
        "R11 empty group leaves counters", {cnt_merged, cnt_split}, {exp_cm[15:0], exp_cs[15:0]});

    // R9: back-pressure holds a merged transaction
    build(VT[2]);
    @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      lane_addr[k*AW +: AW] = ea[k];
      lane_size[k*2 +: 2]   = es[k];
    end
    lane_act = '1; grp_valid = 1'b1;
    @(negedge clk);
    grp_valid = 1'b0;
    repeat (4) begin
      chk(tx_valid && tx_addr == g_base, "R9 held under stall", tx_addr, g_base);
      @(negedge clk);
    end
    // R1: reset mid-group aborts it
    rst_n = 1'b0;
    #1;
    chk(tx_valid == 1'b0 && grp_ready == 1'b1, "R1 abort by reset", {tx_valid, grp_ready}, 1);
    chk(cnt_merged == '0 && cnt_split == '0, "R1 counters cleared", {cnt_merged, cnt_split}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == 1'b0 && grp_done == 1'b0, "R1 idle after abort", {tx_valid, grp_done}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule